// File: doc/BRIEF.md
# Host Request Generator

This block produces the service requests of a parallel host port on a DSP. The port has two data registers: one the host loads for the DSP, and one the DSP loads for the host. The block keeps a full flag for the first register and an empty flag for the second. From these two flags it drives active-low interrupt requests toward the external host. The host can choose one merged request line, or one line for transmit and one for receive. The same two flags also drive request strobes for an on-chip DMA controller, which picks one of them with a 5-bit source code.

Requests toward the host need two enables. One is a request enable on the DSP side. The other is a pair of per-direction enables on the host side, next to a mode bit. While the core is stopped, the port is cut off: every host request output is held high, and host writes to the control bits or the data registers are dropped. DMA transfers touch only the DSP side, so they only move the flags.

Top module: `host_req_gen`

## Requirements
- R1: After reset all three host request outputs are high, every enable and the mode bit are 0, the host-to-DSP register is not full (`dmaRxReq`=0) and the DSP-to-host register is empty (`dmaTxReq`=1).
- R2: Bit 4 of the DSP-side control word is the request enable. While it is 0, `hostReqN`, `hostTxReqN` and `hostRxReqN` are all high.
- R3: Bit 2 of the host control word picks the mode. With 0, only `hostReqN` is used and both split lines are high. With 1, only `hostTxReqN`/`hostRxReqN` are used and `hostReqN` is high.
- R4: Bit 0 of the host control word enables receive requests and bit 1 enables transmit requests. Each one masks its own direction only.
- R5: The receive condition is "DSP-to-host register holds data" (not empty). The transmit condition is "host-to-DSP register empty" (not full). In merged mode `hostReqN` is low when either enabled condition holds.
- R6: A host load sets the full flag and a DSP/DMA unload clears it. A DSP/DMA load clears the empty flag and a host unload sets it. When both strobes of one flag come in the same cycle, the flag ends showing data present: full stays or becomes 1, and empty becomes 0.
- R7: `dmaRxReq` follows the full flag and `dmaTxReq` follows the empty flag, in the cycle the flag changes. `dmaReq` shows the full flag for code 10011, the empty flag for code 10100, and 0 for any other code.
- R8: The host request outputs are registered. They change one clock after the flag or control bit that causes the change.
- R9: While `stopMode` is high, all host request outputs are high. Host control writes, host loads and host unloads are ignored, so after stop the control bits and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopMode | input | 1 | Core in stop mode; port disconnected |
| hostCtlWe | input | 1 | Host write strobe for the host control word |
| hostCtlData | input | 8 | Host control word (bit0 rx enable, bit1 tx enable, bit2 split mode) |
| dspCtlWe | input | 1 | DSP write strobe for the DSP control word |
| dspCtlData | input | 8 | DSP control word (bit4 request enable) |
| hostDataWr | input | 1 | Host loads the host-to-DSP register |
| hostDataRd | input | 1 | Host unloads the DSP-to-host register |
| dspDataRd | input | 1 | DSP or DMA unloads the host-to-DSP register |
| dspDataWr | input | 1 | DSP or DMA loads the DSP-to-host register |
| dmaSrcSel | input | 5 | DMA request source code |
| hostReqN | output | 1 | Merged host request, active low |
| hostTxReqN | output | 1 | Host transmit request, active low |
| hostRxReqN | output | 1 | Host receive request, active low |
| dmaRxReq | output | 1 | DMA request: host-to-DSP register full |
| dmaTxReq | output | 1 | DMA request: DSP-to-host register empty |
| dmaReq | output | 1 | DMA request picked by `dmaSrcSel` |

## Verification
A host-side access and a DSP-side access can hit the same flag in the same cycle. Examples are a host load together with a DSP unload, or a DSP load together with a host unload. The bench pulses both strobes on one edge, once with the flag in each of its two starting states, and reads the result on the DMA strobe one half cycle later. The expected result is that the flag shows data present in every case. A second overlap is stop mode arriving in the same cycle as a host control write and a host load. The bench judges this one after stop is released: the request line must come back to its level from before the stop, and the DMA receive strobe must still be low.

// File: rtl/hreq_pkg.sv
package hreq_pkg;
  // Host control word bit positions (decoded by the host-side driver)
  localparam int HCFG_RX_EN_BIT = 0;
  localparam int HCFG_TX_EN_BIT = 1;
  localparam int HCFG_SPLIT_BIT = 2;
  // DSP control word bit position of the request enable
  localparam int DCFG_REQ_EN_BIT = 4;

  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SRC_RX_FULL  = 5'b10011;
  localparam logic [SEL_W-1:0] SRC_TX_EMPTY = 5'b10100;

  // Request lanes toward the host
  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
  localparam int LANES   = 2;

  typedef struct packed {
    logic splitMode;
    logic txReqEn;
    logic rxReqEn;
  } hostCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setRxFull;
    logic clrRxFull;
    logic setTxEmpty;
    logic clrTxEmpty;
  } flagStrobe_t;
endpackage

// File: rtl/hreq_ctrl.sv
module hreq_ctrl
  import hreq_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopMode,
  input  logic             hostCtlWe,
  input  logic [CTL_W-1:0] hostCtlData,
  input  logic             dspCtlWe,
  input  logic [CTL_W-1:0] dspCtlData,
  input  logic             hostDataWr,
  input  logic             hostDataRd,
  input  logic             dspDataRd,
  input  logic             dspDataWr,
  output hostCfg_t         hostCfg,
  output logic             reqEn,
  output flagStrobe_t      strb
);
  logic     hostLive;
  hostCfg_t cfgNext;
  logic     unusedCtlBits;

  assign hostLive = !stopMode;

  always_comb begin
    cfgNext.rxReqEn   = hostCtlData[HCFG_RX_EN_BIT];
    cfgNext.txReqEn   = hostCtlData[HCFG_TX_EN_BIT];
    cfgNext.splitMode = hostCtlData[HCFG_SPLIT_BIT];
  end

  assign unusedCtlBits = ^{hostCtlData[CTL_W-1:HCFG_SPLIT_BIT+1],
                           dspCtlData[CTL_W-1:DCFG_REQ_EN_BIT+1],
                           dspCtlData[DCFG_REQ_EN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostCfg <= '0;
      reqEn   <= 1'b0;
    end else begin
      if (hostCtlWe && hostLive) hostCfg <= cfgNext;
      if (dspCtlWe)              reqEn   <= dspCtlData[DCFG_REQ_EN_BIT];
    end
  end

  // Host-side strobes are dropped while the port is disconnected
  always_comb begin
    strb.setRxFull  = hostDataWr && hostLive;
    strb.setTxEmpty = hostDataRd && hostLive;
    strb.clrRxFull  = dspDataRd;
    strb.clrTxEmpty = dspDataWr;
  end

  // R9
  stop_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> $stable(hostCfg));
endmodule

// File: rtl/hreq_dpath.sv
module hreq_dpath
  import hreq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobe_t      strb,
  input  hostCfg_t         hostCfg,
  input  logic             reqEn,
  input  logic [SEL_W-1:0] dmaSrcSel,
  output logic             rxFull,
  output logic             txEmpty,
  output logic             mergedRegN,
  output logic             txRegN,
  output logic             rxRegN,
  output logic             dmaReq
);
  logic [LANES-1:0] rawCond;
  logic [LANES-1:0] laneMask;
  logic [LANES-1:0] laneReq;

  // Flags: when both strobes meet, data-present wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      txEmpty <= 1'b1;
    end else begin
      if (strb.setRxFull)      rxFull <= 1'b1;
      else if (strb.clrRxFull) rxFull <= 1'b0;
      if (strb.clrTxEmpty)      txEmpty <= 1'b0;
      else if (strb.setTxEmpty) txEmpty <= 1'b1;
    end
  end

  assign rawCond[LANE_RX]  = !txEmpty;
  assign rawCond[LANE_TX]  = !rxFull;
  assign laneMask[LANE_RX] = hostCfg.rxReqEn;
  assign laneMask[LANE_TX] = hostCfg.txReqEn;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneReq[i] = rawCond[i] && laneMask[i] && reqEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergedRegN <= 1'b1;
      txRegN     <= 1'b1;
      rxRegN     <= 1'b1;
    end else begin
      mergedRegN <= !(!hostCfg.splitMode && (|laneReq));
      txRegN     <= !(hostCfg.splitMode && laneReq[LANE_TX]);
      rxRegN     <= !(hostCfg.splitMode && laneReq[LANE_RX]);
    end
  end

  always_comb begin
    unique case (dmaSrcSel)
      SRC_RX_FULL:  dmaReq = rxFull;
      SRC_TX_EMPTY: dmaReq = txEmpty;
      default:      dmaReq = 1'b0;
    endcase
  end

  // R6
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRxFull |=> rxFull);
  // R6
  tx_load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTxEmpty |=> !txEmpty);
  // R6
  rx_unload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrRxFull && !strb.setRxFull) |=> !rxFull);
  // R2
  req_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqEn |=> (mergedRegN && txRegN && rxRegN));
  // R3
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mergedRegN |-> (txRegN && rxRegN));
endmodule

// File: rtl/host_req_gen.sv
module host_req_gen
  import hreq_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopMode,
  input  logic             hostCtlWe,
  input  logic [CTL_W-1:0] hostCtlData,
  input  logic             dspCtlWe,
  input  logic [CTL_W-1:0] dspCtlData,
  input  logic             hostDataWr,
  input  logic             hostDataRd,
  input  logic             dspDataRd,
  input  logic             dspDataWr,
  input  logic [SEL_W-1:0] dmaSrcSel,
  output logic             hostReqN,
  output logic             hostTxReqN,
  output logic             hostRxReqN,
  output logic             dmaRxReq,
  output logic             dmaTxReq,
  output logic             dmaReq
);
  hostCfg_t    hostCfg;
  flagStrobe_t strb;
  logic        reqEn;
  logic        rxFull;
  logic        txEmpty;
  logic        mergedRegN;
  logic        txRegN;
  logic        rxRegN;

  hreq_ctrl #(.CTL_W(CTL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .stopMode(stopMode),
    .hostCtlWe(hostCtlWe), .hostCtlData(hostCtlData),
    .dspCtlWe(dspCtlWe), .dspCtlData(dspCtlData),
    .hostDataWr(hostDataWr), .hostDataRd(hostDataRd),
    .dspDataRd(dspDataRd), .dspDataWr(dspDataWr),
    .hostCfg(hostCfg), .reqEn(reqEn), .strb(strb)
  );

  hreq_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostCfg(hostCfg), .reqEn(reqEn),
    .dmaSrcSel(dmaSrcSel), .rxFull(rxFull), .txEmpty(txEmpty),
    .mergedRegN(mergedRegN), .txRegN(txRegN), .rxRegN(rxRegN),
    .dmaReq(dmaReq)
  );

  // Stop mode disconnects the host lines at once
  assign hostReqN   = mergedRegN || stopMode;
  assign hostTxReqN = txRegN || stopMode;
  assign hostRxReqN = rxRegN || stopMode;
  assign dmaRxReq   = rxFull;
  assign dmaTxReq   = txEmpty;
endmodule

// File: tb/tb_host_req_gen.sv
module tb_host_req_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopMode = 1'b0;
  logic       hostCtlWe = 1'b0;
  logic [7:0] hostCtlData = '0;
  logic       dspCtlWe = 1'b0;
  logic [7:0] dspCtlData = '0;
  logic       hostDataWr = 1'b0, hostDataRd = 1'b0, dspDataRd = 1'b0, dspDataWr = 1'b0;
  logic [4:0] dmaSrcSel = '0;
  logic       hostReqN, hostTxReqN, hostRxReqN, dmaRxReq, dmaTxReq, dmaReq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_req_gen dut (.*);

  // Vector: [17:15] host ctl, [14] req enable, [13:10] {hostWr,hostRd,dspRd,dspWr},
  // [9] stop, [8:4] dma source code, [3:0] expected {merged,tx,rx,dmaReq}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {3'b011, 1'b0, 4'b0000, 1'b0, 5'b10100, 4'b1111},
    {3'b010, 1'b1, 4'b0000, 1'b0, 5'b10011, 4'b0110},
    {3'b010, 1'b1, 4'b1000, 1'b0, 5'b10011, 4'b1111},
    {3'b001, 1'b1, 4'b0001, 1'b0, 5'b10100, 4'b0110},
    {3'b111, 1'b1, 4'b0000, 1'b0, 5'b10011, 4'b1101},
    {3'b111, 1'b1, 4'b0010, 1'b0, 5'b00000, 4'b1000},
    {3'b101, 1'b1, 4'b0000, 1'b0, 5'b10100, 4'b1100},
    {3'b101, 1'b1, 4'b0100, 1'b0, 5'b10100, 4'b1111},
    {3'b111, 1'b1, 4'b1000, 1'b1, 5'b10011, 4'b1110},
    {3'b011, 1'b1, 4'b0000, 1'b0, 5'b10011, 4'b0110},
    {3'b011, 1'b0, 4'b0000, 1'b0, 5'b10100, 4'b1111}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive for one edge, end at the following negedge
  task automatic step(input logic [2:0] h, input logic hwe, input logic d,
                      input logic dwe, input logic [3:0] ops);
    hostCtlData = {5'b0, h};
    hostCtlWe   = hwe;
    dspCtlData  = {3'b0, d, 4'b0};
    dspCtlWe    = dwe;
    {hostDataWr, hostDataRd, dspDataRd, dspDataWr} = ops;
    @(negedge clk);
    hostCtlWe = 1'b0;
    dspCtlWe  = 1'b0;
    {hostDataWr, hostDataRd, dspDataRd, dspDataWr} = 4'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 host lines", {hostReqN, hostTxReqN, hostRxReqN, 1'b0}, 4'b1110);
    check("R1 dma flags", {2'b00, dmaRxReq, dmaTxReq}, 4'b0001);

    // Table: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NV; i++) begin
      stopMode  = VEC[i][9];
      dmaSrcSel = VEC[i][8:4];
      step(VEC[i][17:15], 1'b1, VEC[i][14], 1'b1, VEC[i][13:10]);
      @(negedge clk);
      check($sformatf("table R2/R3/R4/R5/R7/R9 vec %0d", i),
            {hostReqN, hostTxReqN, hostRxReqN, dmaReq}, VEC[i][3:0]);
    end

    // R8: flag moves first, request one clock later
    step(3'b010, 1'b1, 1'b1, 1'b1, 4'b0000);
    @(negedge clk);
    check("R8 settled", {hostReqN, 3'b000}, 4'b0000);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b1000);
    check("R7 flag same cycle", {3'b000, dmaRxReq}, 4'b0001);
    check("R8 not yet", {hostReqN, 3'b000}, 4'b0000);
    @(negedge clk);
    check("R8 one clock later", {hostReqN, 3'b000}, 4'b1000);

    // R6 same-cycle load and unload
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b1010);
    check("R6 full+both", {3'b000, dmaRxReq}, 4'b0001);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0010);
    check("R6 unload", {3'b000, dmaRxReq}, 4'b0000);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b1010);
    check("R6 empty+both", {3'b000, dmaRxReq}, 4'b0001);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0010);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0101);
    check("R6 tx empty+both", {3'b000, dmaTxReq}, 4'b0000);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0101);
    check("R6 tx full+both", {3'b000, dmaTxReq}, 4'b0000);
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0100);
    check("R6 host unload", {3'b000, dmaTxReq}, 4'b0001);

    // R9: writes in stop are dropped
    @(negedge clk);
    check("R9 before stop", {hostReqN, 3'b000}, 4'b0000);
    stopMode = 1'b1;
    step(3'b000, 1'b1, 1'b0, 1'b0, 4'b1000);
    check("R9 forced high", {hostReqN, hostTxReqN, hostRxReqN, 1'b0}, 4'b1110);
    stopMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 cfg kept", {hostReqN, 3'b000}, 4'b0000);
    check("R9 load dropped", {3'b000, dmaRxReq}, 4'b0000);

    // R4 / R3: independent masks in split mode, both conditions true
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'b0001);
    step(3'b110, 1'b1, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    check("R4 tx only", {hostReqN, hostTxReqN, hostRxReqN, 1'b0}, 4'b1010);
    step(3'b101, 1'b1, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    check("R4 rx only", {hostReqN, hostTxReqN, hostRxReqN, 1'b0}, 4'b1100);
    step(3'b111, 1'b1, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    check("R3 split both", {hostReqN, hostTxReqN, hostRxReqN, 1'b0}, 4'b1000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule